// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces the auto-refresh traffic of a DDR2 memory controller. A down-counting interval timer runs on the controller clock and expires once per programmed interval. Each expiry adds one refresh to a ledger of refreshes that are owed but not yet issued. The command arbiter clears one owed refresh per one-cycle grant. The interval length comes from two cycle-count inputs, one for the normal case-temperature range and one for the hot range. Software computes both from the clock period: about 7.8 µs for normal operation, and 3.9 µs once the case runs above 85 °C.

The ledger lets the arbiter postpone refreshes while it is busy with reads and writes. Whenever any refresh is owed, the block holds a normal-priority request. When the ledger reaches its legal ceiling of eight postponed refreshes, it also raises an urgent request, which the arbiter must serve before other traffic. A change of temperature range is picked up only when the timer reloads, so the interval in progress always completes at its original length.

Two state machines do the work. The timer has the states TM_LOAD and TM_RUN. TM_LOAD follows reset and moves to TM_RUN after one cycle. TM_RUN reloads itself on each expiry. The ledger has the states RQ_IDLE (nothing owed), RQ_OWED (one to seven owed) and RQ_FULL (eight owed). It moves RQ_IDLE to RQ_OWED on an expiry, RQ_OWED to RQ_FULL when the count reaches eight, RQ_FULL to RQ_OWED on a grant, and RQ_OWED to RQ_IDLE when the last owed refresh is granted.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is asserted, and directly after it is released, both `req_o` and `urgent_o` are 0.
- R2: The first rising edge after reset release loads the timer. The first expiry then raises `req_o` after the (N+1)th rising edge, where N is the selected interval in cycles. An interval value of 0 behaves as 1.
- R3: Each timer expiry adds one owed refresh. Expiries repeat every N cycles thereafter.
- R4: `req_o` is 1 exactly when at least one refresh is owed.
- R5: `urgent_o` is 1 exactly when eight refreshes are owed, and it drops after the first grant taken in that state.
- R6: The owed count saturates at eight. An expiry at eight is dropped, so eight grants clear the ledger.
- R7: A grant while nothing is owed has no effect. The count never goes below zero.
- R8: An expiry and a grant in the same cycle leave the owed count unchanged.
- R9: `temp_hot_i` = 1 selects `ivl_hot_i` and 0 selects `ivl_norm_i`. The choice is sampled only at load or reload, so a range change never shortens or lengthens the interval in progress.
- R10: With every request granted promptly, the number of grants over a window of W cycles equals W/N within one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_hot_i | input | 1 | 1 when case temperature is in the extended (above 85 °C) range |
| ivl_norm_i | input | IVL_W | Refresh interval in cycles for the normal range |
| ivl_hot_i | input | IVL_W | Refresh interval in cycles for the extended range |
| grant_i | input | 1 | One-cycle pulse: the arbiter issued one refresh |
| req_o | output | 1 | Normal-priority refresh request |
| urgent_o | output | 1 | Urgent request: the postponement ceiling is reached |

## Verification
The bench first lets the ledger fill without grants. It checks the edge on which the first request appears, an off-by-one in the load cycle would move it. It also checks that urgent asserts on the eighth expiry and not the seventh. It then issues exactly eight grants after extra expiries. A counter that did not saturate would still be requesting after the eighth grant. A stray grant at zero is followed by a check just before the next expiry, so a wrapping counter would show up as a spurious request. A grant that coincides with an expiry must leave one refresh owed. The bench switches the temperature flag mid-interval and checks the timing of the next two expiries, which catches a design that truncates or ignores the running interval. Long auto-granted windows in both ranges confirm the average grant rate.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic {
        TM_LOAD,
        TM_RUN
    } tm_state_e;

    typedef enum logic [1:0] {
        RQ_IDLE,
        RQ_OWED,
        RQ_FULL
    } rq_state_e;

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer
    import refsched_pkg::*;
#(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             temp_hot_i,
    input  logic [IVL_W-1:0] ivl_norm_i,
    input  logic [IVL_W-1:0] ivl_hot_i,
    output logic             tick_o
);

    localparam logic [IVL_W-1:0] ONE = {{(IVL_W-1){1'b0}}, 1'b1};

    tm_state_e        state_q, state_nx;
    logic [IVL_W-1:0] cnt_q, cnt_nx;
    logic [IVL_W-1:0] sel_ivl;
    logic [IVL_W-1:0] load_val;

    // Range choice is only consumed when a load happens.
    always_comb begin
        sel_ivl  = temp_hot_i ? ivl_hot_i : ivl_norm_i;
        load_val = (sel_ivl == '0) ? '0 : (sel_ivl - ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            TM_LOAD: begin
                cnt_nx   = load_val;
                state_nx = TM_RUN;
            end
            TM_RUN: begin
                if (cnt_q == '0) begin
                    cnt_nx = load_val;
                end else begin
                    cnt_nx = cnt_q - ONE;
                end
            end
            default: begin
                state_nx = TM_LOAD;
            end
        endcase
    end

    always_comb begin
        tick_o = (state_q == TM_RUN) && (cnt_q == '0);
    end

endmodule

// File: rtl/refsched_ledger.sv
module refsched_ledger
    import refsched_pkg::*;
#(
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = $clog2(MAX_OWED + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              grant_i,
    output logic [OWED_W-1:0] owed_o,
    output logic              req_o,
    output logic              urgent_o
);

    localparam logic [OWED_W-1:0] ONE  = {{(OWED_W-1){1'b0}}, 1'b1};
    localparam logic [OWED_W-1:0] CEIL = OWED_W'(MAX_OWED);

    rq_state_e         state_q, state_nx;
    logic [OWED_W-1:0] owed_q, owed_nx;
    logic              take;
    logic              add;

    // A grant only counts when something is actually owed; an expiry at the ceiling is dropped.
    always_comb begin
        take = grant_i && (state_q != RQ_IDLE);
        add  = tick_i && (state_q != RQ_FULL);
    end

    always_comb begin
        owed_nx  = owed_q;
        state_nx = state_q;
        unique case (state_q)
            RQ_IDLE: begin
                if (tick_i) begin
                    owed_nx  = ONE;
                    state_nx = RQ_OWED;
                end
            end
            RQ_OWED: begin
                if (add && !take) begin
                    owed_nx = owed_q + ONE;
                end else if (take && !add) begin
                    owed_nx = owed_q - ONE;
                end
                if (owed_nx == '0) begin
                    state_nx = RQ_IDLE;
                end else if (owed_nx == CEIL) begin
                    state_nx = RQ_FULL;
                end
            end
            RQ_FULL: begin
                if (take && !tick_i) begin
                    owed_nx  = owed_q - ONE;
                    state_nx = RQ_OWED;
                end
            end
            default: begin
                owed_nx  = '0;
                state_nx = RQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
            owed_q  <= '0;
        end else begin
            state_q <= state_nx;
            owed_q  <= owed_nx;
        end
    end

    always_comb begin
        req_o    = (state_q != RQ_IDLE);
        urgent_o = (state_q == RQ_FULL);
        owed_o   = owed_q;
    end

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
    parameter int IVL_W    = 16,
    parameter int MAX_OWED = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             temp_hot_i,
    input  logic [IVL_W-1:0] ivl_norm_i,
    input  logic [IVL_W-1:0] ivl_hot_i,
    input  logic             grant_i,
    output logic             req_o,
    output logic             urgent_o
);

    localparam int OWED_W = $clog2(MAX_OWED + 1);

    logic              tick;
    logic [OWED_W-1:0] owed;

    refsched_timer #(
        .IVL_W(IVL_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_hot_i(temp_hot_i),
        .ivl_norm_i(ivl_norm_i),
        .ivl_hot_i (ivl_hot_i),
        .tick_o    (tick)
    );

    refsched_ledger #(
        .MAX_OWED(MAX_OWED),
        .OWED_W  (OWED_W)
    ) u_ledger (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .grant_i (grant_i),
        .owed_o  (owed),
        .req_o   (req_o),
        .urgent_o(urgent_o)
    );

endmodule

// File: rtl/refsched_checker.sv
module refsched_checker #(
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant_i,
    input logic              tick,
    input logic [OWED_W-1:0] owed,
    input logic              req_o,
    input logic              urgent_o
);

    AST_OWED_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OWED_W'(MAX_OWED)); // R6

    AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o |-> req_o); // R5

    AST_REQ_MEANS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (owed != '0)); // R4

    AST_GRANT_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !tick && owed != '0) |=> (owed == $past(owed) - 1'b1)); // R3

    AST_IDLE_GRANT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !tick && owed == '0) |=> (owed == '0)); // R7

    AST_TICK_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && tick && owed != '0) |=> $stable(owed)); // R8

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent_o && !grant_i) |=> urgent_o); // R6

    AST_TICK_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !grant_i && owed < OWED_W'(MAX_OWED)) |=> (owed == $past(owed) + 1'b1)); // R3

endmodule

bind refresh_scheduler refsched_checker #(
    .MAX_OWED(MAX_OWED),
    .OWED_W  (OWED_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant_i (grant_i),
    .tick    (tick),
    .owed    (owed),
    .req_o   (req_o),
    .urgent_o(urgent_o)
);

// File: tb/refresh_scheduler_bench.sv
module refresh_scheduler_bench;

    localparam int IVL_W = 16;
    localparam int N_NORM = 20;
    localparam int N_HOT  = 10;
    localparam int WIN    = 2000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             temp_hot = 1'b0;
    logic [IVL_W-1:0] ivl_norm = IVL_W'(N_NORM);
    logic [IVL_W-1:0] ivl_hot  = IVL_W'(N_HOT);
    logic             grant_man = 1'b0;
    logic             grant_auto = 1'b0;
    logic             grant;
    logic             auto_en = 1'b0;
    logic             cnt_en = 1'b0;
    logic             req, urgent;
    int               cyc = 0;
    int               gcnt = 0;
    int               checks = 0;
    int               errors = 0;
    bit               done = 1'b0;

    always #10 clk = ~clk;

    assign grant = grant_man | grant_auto;

    refresh_scheduler #(.IVL_W(IVL_W), .MAX_OWED(8)) u_refresh_scheduler (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_hot_i(temp_hot),
        .ivl_norm_i(ivl_norm),
        .ivl_hot_i (ivl_hot),
        .grant_i   (grant),
        .req_o     (req),
        .urgent_o  (urgent)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        if (cnt_en && grant) gcnt <= gcnt + 1;
    end

    always @(negedge clk) grant_auto <= auto_en && req;

    // {edge index, expected req, expected urgent}: ledger filling with no grants, normal range
    localparam logic [11:0] FILL_VEC [8] = '{
        {10'd19,  1'b0, 1'b0},
        {10'd20,  1'b1, 1'b0},
        {10'd40,  1'b1, 1'b0},
        {10'd139, 1'b1, 1'b0},
        {10'd159, 1'b1, 1'b0},
        {10'd160, 1'b1, 1'b1},
        {10'd200, 1'b1, 1'b1},
        {10'd215, 1'b1, 1'b1}
    };

    task automatic check_out(input string tag, input logic exp_req, input logic exp_urg);
        checks++;
        if (req !== exp_req || urgent !== exp_urg) begin
            errors++;
            $display("FAIL %s at edge %0d: req/urgent actual %b%b expected %b%b",
                     tag, cyc - 1, req, urgent, exp_req, exp_urg);
        end
    endtask

    task automatic check_num(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    // Move to the falling edge that follows rising edge k (0 = first edge after reset release).
    task automatic to_edge(input int k);
        while (cyc != k + 1) @(negedge clk);
    endtask

    task automatic pulse_grant();
        grant_man = 1'b1;
        @(negedge clk);
        grant_man = 1'b0;
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1 reset held", 1'b0, 1'b0);
        rst_n = 1'b1;
        check_out("R1 reset released", 1'b0, 1'b0);

        // R2/R3/R4/R5: fill phase walked from the vector table
        for (int i = 0; i < 8; i++) begin
            to_edge(int'(FILL_VEC[i][11:2]));
            check_out("R2 R3 R4 R5 fill", FILL_VEC[i][1], FILL_VEC[i][0]);
        end

        // R6: extra expiry at E220 dropped, so eight grants empty the ledger
        to_edge(220);
        check_out("R6 still full", 1'b1, 1'b1);
        pulse_grant();
        check_out("R5 urgent drops after grant", 1'b1, 1'b0);
        for (int g = 0; g < 6; g++) pulse_grant();
        check_out("R6 one left after seven grants", 1'b1, 1'b0);
        pulse_grant();
        check_out("R6 empty after eight grants", 1'b0, 1'b0);

        // R7: grant at zero ignored, seen just before the next expiry
        pulse_grant();
        to_edge(239);
        check_out("R7 idle grant ignored", 1'b0, 1'b0);
        to_edge(240);
        check_out("R3 periodic expiry", 1'b1, 1'b0);

        // R8: grant coincides with expiry at E260
        to_edge(259);
        grant_man = 1'b1;
        @(negedge clk);
        grant_man = 1'b0;
        check_out("R8 tick+grant keeps one", 1'b1, 1'b0);
        pulse_grant();
        check_out("R8 cleared by next grant", 1'b0, 1'b0);

        // R9: switch to hot mid-interval, running interval completes
        to_edge(265);
        temp_hot = 1'b1;
        to_edge(279);
        check_out("R9 interval not truncated", 1'b0, 1'b0);
        to_edge(280);
        check_out("R9 expiry at old length", 1'b1, 1'b0);
        pulse_grant();
        to_edge(289);
        check_out("R9 hot interval pre", 1'b0, 1'b0);
        to_edge(290);
        check_out("R9 hot interval expiry", 1'b1, 1'b0);
        pulse_grant();
        temp_hot = 1'b0;
        to_edge(300);
        check_out("R9 loaded hot interval kept", 1'b1, 1'b0);
        pulse_grant();
        to_edge(319);
        check_out("R9 back to normal pre", 1'b0, 1'b0);
        to_edge(320);
        check_out("R9 back to normal expiry", 1'b1, 1'b0);
        pulse_grant();

        // R10: long-window average rates
        auto_en = 1'b1;
        to_edge(330);
        gcnt = 0;
        cnt_en = 1'b1;
        repeat (WIN) @(negedge clk);
        cnt_en = 1'b0;
        check_num("R10 normal-range grant count", gcnt, WIN / N_NORM - 1, WIN / N_NORM + 1);
        temp_hot = 1'b1;
        repeat (100) @(negedge clk);
        gcnt = 0;
        cnt_en = 1'b1;
        repeat (WIN) @(negedge clk);
        cnt_en = 1'b0;
        check_num("R10 hot-range grant count", gcnt, WIN / N_HOT - 1, WIN / N_HOT + 1);
        checks++;
        if (urgent !== 1'b0) begin
            errors++;
            $display("FAIL R5 urgent under prompt grants: actual %b expected 0", urgent);
        end

        // R1: reset mid-run clears outputs
        auto_en = 1'b0;
        repeat (N_HOT + 2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1 reset mid-run", 1'b0, 1'b0);

        done = 1'b1;
        finish_sim();
    end

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_sim();
        end
    end

endmodule